// File: doc/BRIEF.md
# Configurable Clock Line Generator

This block is a synchronous model of the clock generator found in a programmable-logic block. Four global clock inputs and four product-term signals are sampled on a single fast system clock. From them, three clock lines are produced according to static configuration inputs. Each clock line appears as a one-cycle "active edge" strobe, so downstream logic uses it as an enable on the system clock and no gated clock is ever created.

Line 1 picks one of the global clocks. It can act on that clock's rising edge, its falling edge or both edges, and it is always qualified by the clock-enable input. Line 2 picks a global clock and acts on its rising edge. Its use of the clock enable can be turned on or off. Line 3 either follows the inverse of line 2, which means line 2's falling edge under line 2's gating, or follows the rising edge of a chosen product-term signal. The product-term choice is only legal when line 2 does not use the clock enable. An illegal request raises a configuration-error flag and holds line 3 quiet.

Top module: `clkline_gen`

## Requirements
- R1: While rst_n is low, l1_stb, l2_stb and l3_stb are all 0, even with every clock input held high.
- R2: A level change on a global clock or product-term input creates its edge event exactly once: the strobe is high in the cycle that follows the second rising system-clock edge after the change, and low in the cycles before and after.
- R3: Line 1 edge mode l1_mode: 0 = rising edges only, 1 = falling edges only, 2 = both edges, 3 = no strobe at all.
- R4: Line 1 follows only gclk_in[l1_sel]. Edges on the other global clocks give no l1_stb.
- R5: l2_stb marks rising edges of gclk_in[l2_sel]. With l2_use_en = 1 it is gated by clk_en. With l2_use_en = 0 clk_en has no effect on it.
- R6: With l3_src = 0, l3_stb marks falling edges of gclk_in[l2_sel], with the same clk_en gating as line 2, and never marks rising edges.
- R7: With l3_src = 1 and l2_use_en = 0, l3_stb marks rising edges only of pt_in[l3_pt_sel], whatever the value of clk_en, and config_error is 0.
- R8: With l3_src = 1 and l2_use_en = 1, config_error is 1 and l3_stb stays 0. In every other configuration config_error is 0.
- R9: clk_en acts in the same system-clock cycle: dropping it during a strobe cycle removes l1_stb (and the gated l2_stb) at once, and raising it restores them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all inputs |
| rst_n | input | 1 | Active-low reset |
| gclk_in | input | 4 | Global clock inputs |
| pt_in | input | 4 | Product-term clock inputs |
| clk_en | input | 1 | Clock enable |
| l1_sel | input | 2 | Global clock index for line 1 |
| l1_mode | input | 2 | Line 1 edge mode (see R3) |
| l2_sel | input | 2 | Global clock index for line 2 (line 3 in complement mode uses it too) |
| l2_use_en | input | 1 | Line 2 applies clk_en when 1 |
| l3_src | input | 1 | Line 3 source: 0 = complement of line 2, 1 = product term |
| l3_pt_sel | input | 2 | Product-term index for line 3 |
| l1_stb | output | 1 | Line 1 active-edge strobe |
| l2_stb | output | 1 | Line 2 active-edge strobe |
| l3_stb | output | 1 | Line 3 active-edge strobe |
| config_error | output | 1 | Illegal line 3 source request |

## Verification
The hardest case to reach from the ports is the same-cycle effect of clk_en. The enable must change inside the single cycle in which a synchronized edge is present, and that cycle only comes two system-clock edges after the input toggle. The stimulus counts those edges from the moment the input toggles. It flips clk_en in the middle of the strobe cycle and looks at the outputs on both sides of the flip. Every global-clock edge is also swept against every select, mode and gating setting, so that unselected clocks, the swapped edges of the complement line and the illegal product-term combination are all reached.

// File: rtl/clkline_pkg.sv
package clkline_pkg;

  typedef enum logic [1:0] {
    L1_RISE = 2'd0,
    L1_FALL = 2'd1,
    L1_BOTH = 2'd2,
    L1_OFF  = 2'd3
  } l1_mode_e;

  // Pick the edge event(s) that line 1 reacts to.
  function automatic logic l1_edge(input l1_mode_e mode, input logic rise, input logic fall);
    case (mode)
      L1_RISE: return rise;
      L1_FALL: return fall;
      L1_BOTH: return rise | fall;
      default: return 1'b0;
    endcase
  endfunction

  // Optional enable qualification.
  function automatic logic qualify(input logic ev, input logic use_en, input logic en);
    return ev & (~use_en | en);
  endfunction

  // Inverting a clock swaps its edges: its active (rising) edge is the source's falling edge.
  function automatic logic complement_rise(input logic src_rise, input logic src_fall);
    return src_fall & ~src_rise;
  endfunction

endpackage

// File: rtl/clkline_sync_edge.sv
module clkline_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);

  localparam int TOP = STAGES - 1;

  logic [TOP:0] chain;
  logic         prev;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[TOP-1:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= chain[TOP];
  end

  assign rise = chain[TOP] & ~prev;
  assign fall = ~chain[TOP] & prev;

endmodule

// File: rtl/clkline_line_logic.sv
module clkline_line_logic
  import clkline_pkg::*;
#(
  parameter int NUM_GCLK = 4,
  parameter int NUM_PT   = 4,
  localparam int SEL_W   = (NUM_GCLK > 1) ? $clog2(NUM_GCLK) : 1,
  localparam int PSEL_W  = (NUM_PT > 1) ? $clog2(NUM_PT) : 1
) (
  input  logic [NUM_GCLK-1:0] g_rise,
  input  logic [NUM_GCLK-1:0] g_fall,
  input  logic [NUM_PT-1:0]   p_rise,
  input  logic                clk_en,
  input  logic [SEL_W-1:0]    l1_sel,
  input  logic [1:0]          l1_mode,
  input  logic [SEL_W-1:0]    l2_sel,
  input  logic                l2_use_en,
  input  logic                l3_src,
  input  logic [PSEL_W-1:0]   l3_pt_sel,
  output logic                l1_stb,
  output logic                l2_stb,
  output logic                l3_stb,
  output logic                config_error
);

  // Named internal events
  logic l1_src_rise, l1_src_fall, l1_event;
  logic l2_src_rise, l2_src_fall;
  logic l3_comp_event, l3_pt_event, l3_comp_stb;

  always_comb begin
    l1_src_rise = g_rise[l1_sel];
    l1_src_fall = g_fall[l1_sel];
    l1_event    = l1_edge(l1_mode_e'(l1_mode), l1_src_rise, l1_src_fall);

    l2_src_rise = g_rise[l2_sel];
    l2_src_fall = g_fall[l2_sel];

    l3_comp_event = complement_rise(l2_src_rise, l2_src_fall);
    l3_pt_event   = p_rise[l3_pt_sel];
    l3_comp_stb   = qualify(l3_comp_event, l2_use_en, clk_en);
  end

  assign l1_stb       = qualify(l1_event, 1'b1, clk_en);
  assign l2_stb       = qualify(l2_src_rise, l2_use_en, clk_en);
  assign config_error = l3_src & l2_use_en;
  assign l3_stb       = config_error ? 1'b0 : (l3_src ? l3_pt_event : l3_comp_stb);

endmodule

// File: rtl/clkline_gen.sv
module clkline_gen #(
  parameter int NUM_GCLK    = 4,
  parameter int NUM_PT      = 4,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = (NUM_GCLK > 1) ? $clog2(NUM_GCLK) : 1,
  localparam int PSEL_W     = (NUM_PT > 1) ? $clog2(NUM_PT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_GCLK-1:0] gclk_in,
  input  logic [NUM_PT-1:0]   pt_in,
  input  logic                clk_en,
  input  logic [SEL_W-1:0]    l1_sel,
  input  logic [1:0]          l1_mode,
  input  logic [SEL_W-1:0]    l2_sel,
  input  logic                l2_use_en,
  input  logic                l3_src,
  input  logic [PSEL_W-1:0]   l3_pt_sel,
  output logic                l1_stb,
  output logic                l2_stb,
  output logic                l3_stb,
  output logic                config_error
);

  logic [NUM_GCLK-1:0] g_rise, g_fall;
  logic [NUM_PT-1:0]   p_rise, p_fall;

  generate
    for (genvar gi = 0; gi < NUM_GCLK; gi++) begin : g_gsync
      clkline_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (gclk_in[gi]),
        .rise (g_rise[gi]),
        .fall (g_fall[gi])
      );
    end
    for (genvar pi = 0; pi < NUM_PT; pi++) begin : g_psync
      clkline_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pt_in[pi]),
        .rise (p_rise[pi]),
        .fall (p_fall[pi])
      );
    end
  endgenerate

  logic unused_pfall;
  assign unused_pfall = |p_fall;

  clkline_line_logic #(.NUM_GCLK(NUM_GCLK), .NUM_PT(NUM_PT)) u_lines (
    .g_rise      (g_rise),
    .g_fall      (g_fall),
    .p_rise      (p_rise),
    .clk_en      (clk_en),
    .l1_sel      (l1_sel),
    .l1_mode     (l1_mode),
    .l2_sel      (l2_sel),
    .l2_use_en   (l2_use_en),
    .l3_src      (l3_src),
    .l3_pt_sel   (l3_pt_sel),
    .l1_stb      (l1_stb),
    .l2_stb      (l2_stb),
    .l3_stb      (l3_stb),
    .config_error(config_error)
  );

endmodule

// File: rtl/clkline_chk.sv
module clkline_chk #(
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clk_en,
  input logic [1:0]       l1_mode,
  input logic [SEL_W-1:0] l2_sel,
  input logic             l2_use_en,
  input logic             l3_src,
  input logic             l1_stb,
  input logic             l2_stb,
  input logic             l3_stb,
  input logic             config_error
);

  // R8
  cfg_err_l3_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    config_error |-> !l3_stb);

  // R3
  l1_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l1_mode == 2'd3) |-> !l1_stb);

  // R9
  l1_en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |-> !l1_stb);

  // R5
  l2_en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l2_use_en && !clk_en) |-> !l2_stb);

  // R2
  l2_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l2_stb |=> (!l2_stb || !$stable(l2_sel)));

  // R6
  l3_not_with_l2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!l3_src && l2_stb) |-> !l3_stb);

endmodule

bind clkline_gen clkline_chk #(.SEL_W(SEL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clk_en      (clk_en),
  .l1_mode     (l1_mode),
  .l2_sel      (l2_sel),
  .l2_use_en   (l2_use_en),
  .l3_src      (l3_src),
  .l1_stb      (l1_stb),
  .l2_stb      (l2_stb),
  .l3_stb      (l3_stb),
  .config_error(config_error)
);

// File: tb/clkline_gen_test.sv
module clkline_gen_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] gclk_in, pt_in;
  logic       clk_en;
  logic [1:0] l1_sel, l1_mode, l2_sel, l3_pt_sel;
  logic       l2_use_en, l3_src;
  logic       l1_stb, l2_stb, l3_stb, config_error;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkline_gen uut (
    .clk(clk), .rst_n(rst_n), .gclk_in(gclk_in), .pt_in(pt_in), .clk_en(clk_en),
    .l1_sel(l1_sel), .l1_mode(l1_mode), .l2_sel(l2_sel), .l2_use_en(l2_use_en),
    .l3_src(l3_src), .l3_pt_sel(l3_pt_sel), .l1_stb(l1_stb), .l2_stb(l2_stb),
    .l3_stb(l3_stb), .config_error(config_error)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%0b exp=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic chk_quiet(input string req);
    chk(req, "l1_stb", l1_stb, 1'b0);
    chk(req, "l2_stb", l2_stb, 1'b0);
    chk(req, "l3_stb", l3_stb, 1'b0);
  endtask

  // Global clock edge on index idx; expected strobes computed from the requirements.
  task automatic gclk_event(input int idx, input logic lvl);
    logic e1, e2, e3, gate2;
    gate2 = !l2_use_en || clk_en;
    e1 = clk_en && (idx == int'(l1_sel)) &&
         ((lvl  && (l1_mode == 2'd0 || l1_mode == 2'd2)) ||
          (!lvl && (l1_mode == 2'd1 || l1_mode == 2'd2)));
    e2 = lvl && (idx == int'(l2_sel)) && gate2;
    e3 = !lvl && (idx == int'(l2_sel)) && gate2;
    gclk_in[idx] = lvl;
    @(negedge clk);
    chk_quiet("R2");
    @(negedge clk);
    chk((idx == int'(l1_sel)) ? "R3" : "R4", "l1_stb", l1_stb, e1);
    chk("R5", "l2_stb", l2_stb, e2);
    chk("R6", "l3_stb", l3_stb, e3);
    @(negedge clk);
    chk_quiet("R2");
  endtask

  task automatic pt_event(input int idx, input logic lvl);
    logic e3;
    e3 = lvl && !l2_use_en && (idx == int'(l3_pt_sel));
    pt_in[idx] = lvl;
    @(negedge clk);
    chk("R2", "l3_stb", l3_stb, 1'b0);
    @(negedge clk);
    chk(l2_use_en ? "R8" : "R7", "l3_stb", l3_stb, e3);
    chk(l2_use_en ? "R8" : "R7", "config_error", config_error, l2_use_en);
    chk("R7", "l1_stb", l1_stb, 1'b0);
    chk("R7", "l2_stb", l2_stb, 1'b0);
    @(negedge clk);
    chk("R2", "l3_stb", l3_stb, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL R2 watchdog act=hung exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; gclk_in = 4'hF; pt_in = 4'hF; clk_en = 1'b1;
    l1_sel = 2'd0; l1_mode = 2'd2; l2_sel = 2'd0; l2_use_en = 1'b0;
    l3_src = 1'b0; l3_pt_sel = 2'd0;
    repeat (4) @(negedge clk);
    chk_quiet("R1");
    chk("R1", "config_error", config_error, 1'b0);
    gclk_in = 4'h0; pt_in = 4'h0;
    repeat (3) @(negedge clk);
    chk_quiet("R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_quiet("R1");

    // Main sweep: every global clock edge against every line 1/2/3 setting
    l3_src = 1'b0;
    for (int s1 = 0; s1 < 4; s1++)
      for (int m = 0; m < 4; m++)
        for (int s2 = 0; s2 < 4; s2++)
          for (int cfg = 0; cfg < 4; cfg++) begin
            l1_sel = 2'(s1); l1_mode = 2'(m); l2_sel = 2'(s2);
            clk_en = cfg[0]; l2_use_en = cfg[1];
            chk("R8", "config_error", config_error, 1'b0);
            for (int i = 0; i < 4; i++) begin
              gclk_event(i, 1'b1);
              gclk_event(i, 1'b0);
            end
          end

    // Product-term source sweep, legal and illegal
    l3_src = 1'b1; l1_mode = 2'd2;
    for (int j = 0; j < 4; j++)
      for (int cfg = 0; cfg < 4; cfg++) begin
        l3_pt_sel = 2'(j); clk_en = cfg[0]; l2_use_en = cfg[1];
        for (int k = 0; k < 4; k++) begin
          pt_event(k, 1'b1);
          pt_event(k, 1'b0);
        end
      end

    // Same-cycle effect of clk_en
    l3_src = 1'b0; l1_sel = 2'd1; l1_mode = 2'd2; l2_sel = 2'd1;
    l2_use_en = 1'b1; clk_en = 1'b1;
    @(negedge clk);
    gclk_in[1] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    clk_en = 1'b0;
    #1;
    chk("R9", "l1_stb", l1_stb, 1'b0);
    chk("R9", "l2_stb", l2_stb, 1'b0);
    clk_en = 1'b1;
    #1;
    chk("R9", "l1_stb", l1_stb, 1'b1);
    chk("R9", "l2_stb", l2_stb, 1'b1);
    l2_use_en = 1'b0; clk_en = 1'b0;
    #1;
    chk("R5", "l2_stb", l2_stb, 1'b1);
    chk("R9", "l1_stb", l1_stb, 1'b0);
    @(negedge clk);
    clk_en = 1'b1;
    #1;
    chk_quiet("R2");
    gclk_in[1] = 1'b0;
    repeat (4) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule